// File: doc/BRIEF.md
# Fuse Row Read Access Filter

This block serves host reads of one complete 32-bit row of a one-time-programmable fuse store. The host writes a read address holding an array number and a row number. The block then decides whether that row may be seen at all. If it may, the block fetches the row through a simple request/valid fuse interface. It clears every column that is not on a fixed, hard-wired allow-list for that row and latches the result into a read-data register.

Reads the filter refuses never reach the fuse interface. A refused read sets the read-data register to zero and raises an error flag in place of the done flag. This keeps protected bits, such as key material, out of reach of a host reading rows in general. The allow-list is a per-row column mask for array 0, where the sensitive rows live. Array 1 is never reachable. Arrays 2 and 3 are general storage: each maps down by one onto the physical fuse arrays and is readable in full.

The block handles one read at a time. Address writes that arrive while a read is in flight are dropped. Storage of the fuse array itself and any shadow copy of fuse contents lie outside this block.

Top module: `fuse_row_rd_filter`

## Requirements
- R1: The read address is decoded as follows: row number from bits 10:5 and array number from bits 12:11. Bits 4:0 and bits 31:13 have no effect on which row is read or on the result.
- R2: For array 0, the allowed columns of each row are fixed as follows. Rows 8 to 15, 20, 22, 23 and 40 to 63 allow all 32 columns. Row 0 allows columns 28 to 31. Row 16 allows columns 0 to 7 and 10 to 16. Row 17 allows columns 0 to 2. Row 21 allows columns 0 to 23 and 29 to 31.
- R3: Any array-0 row whose allowed-column mask is empty is denied: rows 1 to 7, 18, 19 and 24 to 39. A denied read sets rd_data to 0, sets rd_error to 1 and sets rd_done to 0, and it never asserts fuse_req.
- R4: Array numbers 2 and 3 are presented on fuse_addr as physical arrays 1 and 2, with all columns allowed. fuse_addr carries the physical array in its top two bits and the row in its low six bits. Array 0 is presented as physical array 0.
- R5: A read of array 1 is always denied, with the same result as R3.
- R6: On a granted read, rd_data becomes the returned fuse row ANDed with the row's allowed-column mask, rd_error becomes 0 and rd_done becomes 1.
- R7: A read is decided one clock after the address write. A denied read updates its result at that edge. A granted read raises fuse_req from that edge until the clock edge at which fuse_rvalid is sampled high, and its result is latched at that same edge.
- R8: rd_data, rd_done and rd_error change only when a read completes or is denied. Address writes made while a read is in flight are ignored and leave fuse_addr unchanged.
- R9: After reset, rd_data is 0, rd_done is 0, rd_error is 0 and fuse_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_we | input | 1 | Host write strobe for the read address |
| addr_wdata | input | 32 | Read address: array in bits 12:11, row in bits 10:5 |
| fuse_req | output | 1 | Row fetch request to the fuse store, held until valid |
| fuse_addr | output | 8 | Physical array (7:6) and row (5:0) being fetched |
| fuse_rvalid | input | 1 | Fuse store returns row data this cycle |
| fuse_rdata | input | 32 | Raw fuse row contents |
| rd_data | output | 32 | Masked row result, read-only to the host |
| rd_done | output | 1 | Last read completed successfully |
| rd_error | output | 1 | Last read was denied |

## Verification
A wrong allow mask or a wrong denial decision appears at the ports on the first read of the affected row. Its effect is either a bit leaking into rd_data on the completing edge, or a fuse_req raised one clock after the write where rd_error should have risen. A corrupted sequencer state appears as fuse_req stuck or missing on the clock after a write, or as an address taken while busy, which then shows on fuse_addr within one cycle. A sweep over every array and row, with fuse latencies from zero to three cycles, therefore reaches every allow-list entry and every sequencer transition.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  localparam int FR_DATA_W  = 32;
  localparam int FR_ROW_W   = 6;
  localparam int FR_ARR_W   = 2;
  localparam int FR_ROW_LSB = 5;
  localparam int FR_ADDR_W  = 32;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECIDE = 2'd1,
    ST_FETCH  = 2'd2
  } rd_state_e;

  // Column allowed in a row of array 0 (fixed allow-list).
  function automatic logic col_allowed(input logic [FR_ROW_W-1:0] row,
                                       input int unsigned col);
    int unsigned r;
    r = int'(row);
    if (r == 0)                 return (col >= 28);
    if (r >= 8 && r <= 15)      return 1'b1;
    if (r == 16)                return (col <= 7) || (col >= 10 && col <= 16);
    if (r == 17)                return (col <= 2);
    if (r == 20)                return 1'b1;
    if (r == 21)                return (col <= 23) || (col >= 29);
    if (r == 22 || r == 23)     return 1'b1;
    if (r >= 40)                return 1'b1;
    return 1'b0;
  endfunction

  // Physical array seen by the fuse store for a host array number.
  function automatic logic [FR_ARR_W-1:0] phys_array(input logic [FR_ARR_W-1:0] arr);
    return (arr >= 2) ? FR_ARR_W'(arr - 1'b1) : '0;
  endfunction

endpackage

// File: rtl/fuse_rd_decode.sv
module fuse_rd_decode
  import fuse_rd_pkg::*;
#(
  parameter int DATA_W = FR_DATA_W,
  parameter int ROW_W  = FR_ROW_W,
  parameter int ARR_W  = FR_ARR_W
) (
  input  logic [ARR_W+ROW_W-1:0] addr_fld,
  output logic [DATA_W-1:0]      col_mask,
  output logic                   allow,
  output logic [ARR_W+ROW_W-1:0] fuse_addr
);
  localparam int FLD_W = ARR_W + ROW_W;

  logic [ROW_W-1:0] row;
  logic [ARR_W-1:0] arr;
  logic [DATA_W-1:0] ary0_mask;

  assign row = addr_fld[ROW_W-1:0];
  assign arr = addr_fld[FLD_W-1:ROW_W];

  for (genvar c = 0; c < DATA_W; c++) begin : g_col
    assign ary0_mask[c] = col_allowed(row, c);
  end

  always_comb begin
    col_mask = '0;
    allow    = 1'b0;
    case (arr)
      2'd0: begin
        col_mask = ary0_mask;
        allow    = |ary0_mask;
      end
      2'd2, 2'd3: begin
        col_mask = '1;
        allow    = 1'b1;
      end
      default: begin
        col_mask = '0;
        allow    = 1'b0;
      end
    endcase
  end

  assign fuse_addr = {phys_array(arr), row};

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int FLD_W = FR_ARR_W + FR_ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_we,
  input  logic [FLD_W-1:0] addr_in,
  input  logic             allow,
  input  logic             fuse_rvalid,
  output logic [FLD_W-1:0] addr_q,
  output logic             fuse_req,
  output logic             wr_accept,
  output logic             grant_evt,
  output logic             deny_evt,
  output logic             done_evt
);
  rd_state_e state_q;

  assign wr_accept = (state_q == ST_IDLE) && addr_we;
  assign grant_evt = (state_q == ST_DECIDE) && allow;
  assign deny_evt  = (state_q == ST_DECIDE) && !allow;
  assign fuse_req  = (state_q == ST_FETCH);
  assign done_evt  = fuse_req && fuse_rvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (addr_we) begin
          addr_q  <= addr_in;
          state_q <= ST_DECIDE;
        end
        ST_DECIDE: state_q <= allow ? ST_FETCH : ST_IDLE;
        ST_FETCH:  if (fuse_rvalid) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: every accepted write is decided on the next edge
  a_r7_decide_next: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (grant_evt || deny_evt));

  // R7: a grant raises the fetch request on the following cycle
  a_r7_req_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |=> fuse_req);

  // R3: a denial never leads to a fetch
  a_r3_no_fetch_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
    deny_evt |=> !fuse_req);

  // R8: writes while busy leave the captured address alone
  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && addr_we) |=> $stable(addr_q));

endmodule

// File: rtl/fuse_rd_result.sv
module fuse_rd_result
  import fuse_rd_pkg::*;
#(
  parameter int DATA_W = FR_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deny_evt,
  input  logic              done_evt,
  input  logic [DATA_W-1:0] fuse_rdata,
  input  logic [DATA_W-1:0] col_mask,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic              rd_error
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_done  <= 1'b0;
      rd_error <= 1'b0;
    end else if (deny_evt) begin
      rd_data  <= '0;
      rd_done  <= 1'b0;
      rd_error <= 1'b1;
    end else if (done_evt) begin
      rd_data  <= fuse_rdata & col_mask;
      rd_done  <= 1'b1;
      rd_error <= 1'b0;
    end
  end

  // R3: denied read gives zero data and error
  a_r3_deny_result: assert property (@(posedge clk) disable iff (!rst_n)
    deny_evt |=> (rd_data == '0 && rd_error && !rd_done));

  // R6: granted read gives masked data and done
  a_r6_success_result: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (rd_done && !rd_error && rd_data == $past(fuse_rdata & col_mask)));

  // R8: result holds between completions
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(deny_evt || done_evt) |=> ($stable(rd_data) && $stable(rd_done) && $stable(rd_error)));

  // R6: done and error never both set
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_done && rd_error));

endmodule

// File: rtl/fuse_row_rd_filter.sv
module fuse_row_rd_filter
  import fuse_rd_pkg::*;
#(
  parameter int DATA_W  = FR_DATA_W,
  parameter int ADDR_W  = FR_ADDR_W,
  parameter int ROW_W   = FR_ROW_W,
  parameter int ARR_W   = FR_ARR_W,
  parameter int ROW_LSB = FR_ROW_LSB
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   addr_we,
  input  logic [ADDR_W-1:0]      addr_wdata,
  output logic                   fuse_req,
  output logic [ARR_W+ROW_W-1:0] fuse_addr,
  input  logic                   fuse_rvalid,
  input  logic [DATA_W-1:0]      fuse_rdata,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_done,
  output logic                   rd_error
);
  localparam int FLD_W = ARR_W + ROW_W;
  localparam int FLD_HI = ROW_LSB + FLD_W - 1;

  logic [FLD_W-1:0]  addr_in;
  logic [FLD_W-1:0]  addr_q;
  logic [DATA_W-1:0] col_mask;
  logic              allow;
  logic              wr_accept, grant_evt, deny_evt, done_evt;
  logic              addr_unused_bits;

  assign addr_in          = addr_wdata[FLD_HI:ROW_LSB];
  assign addr_unused_bits = ^{addr_wdata[ADDR_W-1:FLD_HI+1], addr_wdata[ROW_LSB-1:0]};

  fuse_rd_seq #(.FLD_W(FLD_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_we     (addr_we),
    .addr_in     (addr_in),
    .allow       (allow),
    .fuse_rvalid (fuse_rvalid),
    .addr_q      (addr_q),
    .fuse_req    (fuse_req),
    .wr_accept   (wr_accept),
    .grant_evt   (grant_evt),
    .deny_evt    (deny_evt),
    .done_evt    (done_evt)
  );

  fuse_rd_decode #(.DATA_W(DATA_W), .ROW_W(ROW_W), .ARR_W(ARR_W)) u_dec (
    .addr_fld  (addr_q),
    .col_mask  (col_mask),
    .allow     (allow),
    .fuse_addr (fuse_addr)
  );

  fuse_rd_result #(.DATA_W(DATA_W)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .deny_evt   (deny_evt),
    .done_evt   (done_evt),
    .fuse_rdata (fuse_rdata),
    .col_mask   (col_mask),
    .rd_data    (rd_data),
    .rd_done    (rd_done),
    .rd_error   (rd_error)
  );

  // R5: array 1 is always refused at the decision point
  a_r5_array1_denied: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_evt || deny_evt) && addr_q[FLD_W-1:ROW_W] == 2'd1) |-> deny_evt);

  // R4: upper arrays are fetched one array lower
  a_r4_remap: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_req && addr_q[FLD_W-1:ROW_W] >= 2'd2) |->
      (fuse_addr[FLD_W-1:ROW_W] == addr_q[FLD_W-1:ROW_W] - 2'd1));

  // R7: decision events are mutually exclusive
  a_r7_events_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_evt, deny_evt, done_evt, wr_accept && fuse_req}));

  // R8: the fetch address is steady for the whole request
  a_r8_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_req && !fuse_rvalid) |=> $stable(fuse_addr));

endmodule

// File: tb/fuse_row_rd_filter_bench.sv
module fuse_row_rd_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_we = 1'b0;
  logic [31:0] addr_wdata = '0;
  logic        fuse_req;
  logic [7:0]  fuse_addr;
  logic        fuse_rvalid = 1'b0;
  logic [31:0] fuse_rdata = '0;
  logic [31:0] rd_data;
  logic        rd_done, rd_error;

  int checks = 0;
  int fails  = 0;
  logic [31:0] prev_data = '0;
  logic        prev_done = 1'b0, prev_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_row_rd_filter u_fuse_row_rd_filter (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .fuse_req(fuse_req), .fuse_addr(fuse_addr), .fuse_rvalid(fuse_rvalid),
    .fuse_rdata(fuse_rdata), .rd_data(rd_data), .rd_done(rd_done), .rd_error(rd_error)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Allowed-column mask written as row ranges with shifted spans.
  function automatic logic [31:0] span(input int lo, input int hi);
    logic [32:0] m;
    m = ((33'd1 << (hi + 1)) - 33'd1) & ~((33'd1 << lo) - 33'd1);
    return m[31:0];
  endfunction

  function automatic logic [31:0] exp_mask(input int arr, input int row);
    if (arr == 1) return 32'h0;
    if (arr >= 2) return 32'hFFFF_FFFF;
    case (row)
      0:  return span(28, 31);
      16: return span(0, 7) | span(10, 16);
      17: return span(0, 2);
      21: return span(0, 23) | span(29, 31);
      default: begin
        if ((row >= 8 && row <= 15) || row == 20 || row == 22 || row == 23 || row >= 40)
          return 32'hFFFF_FFFF;
        return 32'h0;
      end
    endcase
  endfunction

  function automatic logic [31:0] row_value(input int arr, input int row, input int pat);
    if (pat == 1) return 32'hFFFF_FFFF;
    return 32'h9E37_79B9 * (arr * 64 + row + 1) ^ 32'h0F0F_3C3C;
  endfunction

  task automatic do_read(input int arr, input int row, input int lat, input int pat,
                         input logic [31:0] junk);
    logic [31:0] mask, val, exp_data;
    logic [7:0]  exp_addr;
    bit denied;
    mask   = exp_mask(arr, row);
    denied = (mask == 32'h0);
    val    = row_value(arr, row, pat);
    exp_data = val & mask;
    exp_addr = {(arr >= 2) ? 2'(arr - 1) : 2'd0, 6'(row)};

    // R1: junk in reserved bits 4:0 and 31:13
    addr_wdata = (junk & 32'hFFFF_E01F) | (32'(arr) << 11) | (32'(row) << 5);
    addr_we = 1'b1;
    @(negedge clk);
    addr_we = 1'b0;
    check(fuse_req == 1'b0, "R7 no request before decision", 32'(fuse_req), 32'h0);
    check(rd_data == prev_data, "R8 result held while deciding", rd_data, prev_data);
    @(negedge clk);
    if (denied) begin
      check(rd_data == 32'h0, "R3/R5 denied data", rd_data, 32'h0);
      check(rd_error == 1'b1 && rd_done == 1'b0, "R3/R5 denied flags",
            {30'h0, rd_error, rd_done}, 32'h2);
      check(fuse_req == 1'b0, "R3 no fetch on denial", 32'(fuse_req), 32'h0);
      prev_data = 32'h0; prev_done = 1'b0; prev_err = 1'b1;
    end else begin
      check(fuse_req == 1'b1, "R7 request one cycle after decision", 32'(fuse_req), 32'h1);
      check(fuse_addr == exp_addr, "R1/R4 fetch address", 32'(fuse_addr), 32'(exp_addr));
      for (int w = 0; w < lat; w++) begin
        if (w == 0) begin
          // R8: write while busy must be dropped
          addr_wdata = 32'h0000_0A20 ^ (32'(row + 1) << 5);
          addr_we = 1'b1;
        end else addr_we = 1'b0;
        @(negedge clk);
        check(fuse_req == 1'b1, "R7 request held until valid", 32'(fuse_req), 32'h1);
        check(fuse_addr == exp_addr, "R8 busy write ignored", 32'(fuse_addr), 32'(exp_addr));
        check(rd_data == prev_data && rd_done == prev_done && rd_error == prev_err,
              "R8 result held while fetching", rd_data, prev_data);
      end
      addr_we = 1'b0;
      fuse_rvalid = 1'b1;
      fuse_rdata  = val;
      @(negedge clk);
      fuse_rvalid = 1'b0;
      fuse_rdata  = 32'hDEAD_BEEF;
      check(rd_data == exp_data, "R2/R6 masked data", rd_data, exp_data);
      check(rd_done == 1'b1 && rd_error == 1'b0, "R6 success flags",
            {30'h0, rd_error, rd_done}, 32'h1);
      check(fuse_req == 1'b0, "R7 request drops after valid", 32'(fuse_req), 32'h0);
      prev_data = exp_data; prev_done = 1'b1; prev_err = 1'b0;
    end
    @(negedge clk);
    check(rd_data == prev_data, "R8 result held when idle", rd_data, prev_data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data == 32'h0 && rd_done == 1'b0 && rd_error == 1'b0 && fuse_req == 1'b0,
          "R9 reset state", {rd_data[29:0], rd_done, rd_error}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int arr = 0; arr < 4; arr++)
      for (int row = 0; row < 64; row++)
        do_read(arr, row, row % 4, 0, 32'hA5A5_5A5A ^ 32'(row * 7919));
    for (int row = 0; row < 64; row++)
      do_read(0, row, (row + 1) % 3, 1, ~32'(row));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule